// File: doc/BRIEF.md
# Modem Handshake Sequencer (Terminal Side)

This block is the control-line sequencer that sits beside a serial transmitter on the terminal end of an asynchronous link. It drives the terminal-ready and request-to-send lines toward a modem and reads back the modem's ring, ready, carrier and clear-to-send lines. It takes a session through three phases: call setup, data transfer and teardown. Software starts a call in one of two roles. In the originate role it raises terminal-ready at once. In the answer role it waits for ring and then raises terminal-ready to accept the call. A dedicated-line option skips dialing and waits only for modem-ready.

During data transfer the block raises request-to-send. It opens a transmit-permit strobe to the transmitter only while clear-to-send is present. On hang-up, or when the modem drops its ready or carrier line, the block releases the lines in order. Request-to-send drops first. Terminal-ready is held until the modem has released clear-to-send, carrier and ready. A programmable cycle limit on each wait step aborts a step that never completes and leaves a sticky error flag.

Top module: `modem_hs_seq`

## Requirements
- R1: After reset, term_rdy, req_to_send, tx_permit, link_up and err_timeout are all 0.
- R2: With dedicated_line=0, a call_req in the idle state raises term_rdy. link_up rises only once both modem_rdy and carrier are 1; either one alone is not enough.
- R3: An answer_req in the idle state arms the block with term_rdy still 0. term_rdy rises only after ring goes to 1, and link_up then follows the R2 condition.
- R4: With dedicated_line=1 at call_req, term_rdy stays 0 for the whole session, and link_up rises on modem_rdy alone.
- R5: While link_up is 1, a send_req level raises req_to_send. tx_permit is 1 only while the state is data transfer and clr_to_send is 1, and it returns to 0 when clr_to_send drops.
- R6: When send_req returns to 0, req_to_send and tx_permit drop while link_up stays 1.
- R7: A hangup_req during the link-up phase drops req_to_send and link_up first. term_rdy stays 1 until clr_to_send, then modem_rdy and carrier are all 0, and only then returns to 0.
- R8: If modem_rdy drops during the link-up phase, or carrier drops in a non-dedicated session, the block enters the R7 teardown without any request. Carrier is ignored in a dedicated session.
- R9: In a timed wait step (waiting for the connection, for clr_to_send, or for the modem lines to drop in teardown), staying more than tmo_cycles cycles returns the block to idle with term_rdy and req_to_send at 0 and sets err_timeout. A tmo_cycles value of 0 disables the limit.
- R10: err_timeout stays 1 until the next call_req or answer_req is accepted in the idle state, which clears it.
- R11: Waiting for ring is not timed. A hangup_req while waiting for ring returns the block to idle, after which ring has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_req | input | 1 | Start an originating (or dedicated) session; one-cycle pulse |
| answer_req | input | 1 | Arm the answer role; one-cycle pulse |
| send_req | input | 1 | Level: data waiting to be sent |
| hangup_req | input | 1 | End the session; one-cycle pulse |
| dedicated_line | input | 1 | Session uses a dedicated line with no dialing |
| tmo_cycles | input | TMO_W | Wait-step limit in cycles; 0 disables |
| ring | input | 1 | Modem ring indication (asynchronous) |
| modem_rdy | input | 1 | Modem ready (asynchronous) |
| carrier | input | 1 | Carrier detect (asynchronous) |
| clr_to_send | input | 1 | Clear to send (asynchronous) |
| term_rdy | output | 1 | Terminal ready line to the modem |
| req_to_send | output | 1 | Request to send line to the modem |
| tx_permit | output | 1 | Transmitter may release a character |
| link_up | output | 1 | Connection established |
| err_timeout | output | 1 | Sticky wait-step timeout flag |

## Verification
The block is driven through whole sessions in each role: originate, answer after a ring, and dedicated. Each session raises the modem lines one at a time, so the bench can tell a correct AND of ready and carrier from an early link-up on either line alone. Clear-to-send is toggled inside the data phase to separate gating by clear-to-send from gating by state alone. Teardown is started both by request and by a carrier loss, with the modem lines released one by one, which exposes any early drop of terminal-ready. A connection that never arrives is run with a finite limit, then with a zero limit, and a long unanswered ring wait is run too. Together these separate a timed step from an untimed one and show when the sticky flag is set and cleared.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_RING_WAIT = 3'd1,
      ST_CONN_WAIT = 3'd2,
      ST_LINKED    = 3'd3,
      ST_CTS_WAIT  = 3'd4,
      ST_DATA      = 3'd5,
      ST_TEAR_CTS  = 3'd6,
      ST_TEAR_LINE = 3'd7
   } mhs_state_e;

   function automatic logic is_timed(mhs_state_e s);
      return (s == ST_CONN_WAIT) || (s == ST_CTS_WAIT) ||
             (s == ST_TEAR_CTS)  || (s == ST_TEAR_LINE);
   endfunction

endpackage

// File: rtl/mhs_line_sync.sv
module mhs_line_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);

   generate
      if (STAGES == 0) begin : g_pass
         assign d_sync = d_async;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d_async;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign d_sync = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mhs_wait_timer.sv
module mhs_wait_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);

   logic [TMO_W-1:0] cnt_q;

   assign expired = run && (limit != '0) && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart)          cnt_q <= '0;
      else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/mhs_seq_fsm.sv
module mhs_seq_fsm
   import mhs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       call_req,
   input  logic       answer_req,
   input  logic       send_req,
   input  logic       hangup_req,
   input  logic       dedicated_line,
   input  logic       ring_s,
   input  logic       dsr_s,
   input  logic       cd_s,
   input  logic       cts_s,
   input  logic       expired,
   output mhs_state_e state,
   output logic       timed,
   output logic       restart,
   output logic       ded_sess,
   output logic       err_flag
);

   mhs_state_e state_q, state_d;
   logic       ded_q, err_q;
   logic       line_up, abort, start;

   assign line_up = dsr_s && (cd_s || ded_q);
   assign start   = (state_q == ST_IDLE) && (call_req || answer_req);

   always_comb begin
      state_d = state_q;
      abort   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (call_req)        state_d = ST_CONN_WAIT;
            else if (answer_req) state_d = ST_RING_WAIT;
         end
         ST_RING_WAIT: begin
            if (hangup_req)  state_d = ST_IDLE;
            else if (ring_s) state_d = ST_CONN_WAIT;
         end
         ST_CONN_WAIT: begin
            if (hangup_req)   state_d = ST_IDLE;
            else if (line_up) state_d = ST_LINKED;
            else if (expired) abort   = 1'b1;
         end
         ST_LINKED: begin
            if (hangup_req || !line_up) state_d = ST_TEAR_CTS;
            else if (send_req)          state_d = ST_CTS_WAIT;
         end
         ST_CTS_WAIT: begin
            if (hangup_req || !line_up) state_d = ST_TEAR_CTS;
            else if (!send_req)         state_d = ST_LINKED;
            else if (cts_s)             state_d = ST_DATA;
            else if (expired)           abort   = 1'b1;
         end
         ST_DATA: begin
            if (hangup_req || !line_up) state_d = ST_TEAR_CTS;
            else if (!send_req)         state_d = ST_LINKED;
         end
         ST_TEAR_CTS: begin
            if (!cts_s)       state_d = ded_q ? ST_IDLE : ST_TEAR_LINE;
            else if (expired) abort   = 1'b1;
         end
         ST_TEAR_LINE: begin
            if (!dsr_s && !cd_s) state_d = ST_IDLE;
            else if (expired)    abort   = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
      if (abort) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ded_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start) ded_q <= call_req && dedicated_line;
         if (abort)      err_q <= 1'b1;
         else if (start) err_q <= 1'b0;
      end
   end

   assign state    = state_q;
   assign timed    = is_timed(state_q);
   assign restart  = (state_d != state_q);
   assign ded_sess = ded_q;
   assign err_flag = err_q;

endmodule

// File: rtl/modem_hs_seq.sv
module modem_hs_seq
   import mhs_pkg::*;
#(
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             call_req,
   input  logic             answer_req,
   input  logic             send_req,
   input  logic             hangup_req,
   input  logic             dedicated_line,
   input  logic [TMO_W-1:0] tmo_cycles,
   input  logic             ring,
   input  logic             modem_rdy,
   input  logic             carrier,
   input  logic             clr_to_send,
   output logic             term_rdy,
   output logic             req_to_send,
   output logic             tx_permit,
   output logic             link_up,
   output logic             err_timeout
);

   localparam int N_LINES = 4;

   generate
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo_w
         $error("modem_hs_seq: TMO_W must lie in 2..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("modem_hs_seq: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [N_LINES-1:0] lines_s;
   logic               ring_s, dsr_s, cd_s, cts_s;
   logic               expired, timed, restart, ded_sess;
   mhs_state_e         state;

   mhs_line_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ring, modem_rdy, carrier, clr_to_send}),
      .d_sync  (lines_s)
   );
   assign {ring_s, dsr_s, cd_s, cts_s} = lines_s;

   mhs_wait_timer #(.TMO_W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (timed),
      .limit   (tmo_cycles),
      .expired (expired)
   );

   mhs_seq_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .call_req       (call_req),
      .answer_req     (answer_req),
      .send_req       (send_req),
      .hangup_req     (hangup_req),
      .dedicated_line (dedicated_line),
      .ring_s         (ring_s),
      .dsr_s          (dsr_s),
      .cd_s           (cd_s),
      .cts_s          (cts_s),
      .expired        (expired),
      .state          (state),
      .timed          (timed),
      .restart        (restart),
      .ded_sess       (ded_sess),
      .err_flag       (err_timeout)
   );

   assign term_rdy    = !ded_sess && (state != ST_IDLE) && (state != ST_RING_WAIT);
   assign req_to_send = (state == ST_CTS_WAIT) || (state == ST_DATA);
   assign link_up     = (state == ST_LINKED) || (state == ST_CTS_WAIT) ||
                        (state == ST_DATA);
   assign tx_permit   = (state == ST_DATA) && cts_s;

endmodule

// File: rtl/modem_hs_seq_chk.sv
module modem_hs_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic call_req,
   input logic answer_req,
   input logic term_rdy,
   input logic req_to_send,
   input logic tx_permit,
   input logic link_up,
   input logic err_timeout
);

   // R5: the transmitter is only released under an active request on a live link
   assert_permit_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_permit |-> (req_to_send && link_up));

   // R8: request-to-send never outlives the link
   assert_rts_within_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_to_send |-> link_up);

   // R9: an abort leaves both control lines released
   assert_abort_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_timeout) |-> (!term_rdy && !req_to_send && !link_up));

   // R10: the flag only clears on a newly accepted session
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_timeout) |-> $past(call_req || answer_req));

endmodule

bind modem_hs_seq modem_hs_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .call_req    (call_req),
   .answer_req  (answer_req),
   .term_rdy    (term_rdy),
   .req_to_send (req_to_send),
   .tx_permit   (tx_permit),
   .link_up     (link_up),
   .err_timeout (err_timeout)
);

// File: tb/modem_hs_seq_bench.sv
`timescale 1ns/1ps
module modem_hs_seq_bench;

   localparam int TMO_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic call_req = 0, answer_req = 0, send_req = 0, hangup_req = 0;
   logic dedicated_line = 0;
   logic [TMO_W-1:0] tmo_cycles = 16'd40;
   logic ring = 0, modem_rdy = 0, carrier = 0, clr_to_send = 0;
   logic term_rdy, req_to_send, tx_permit, link_up, err_timeout;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   modem_hs_seq #(.TMO_W(TMO_W), .SYNC_STAGES(2)) u_modem_hs_seq (
      .clk(clk), .rst_n(rst_n),
      .call_req(call_req), .answer_req(answer_req), .send_req(send_req),
      .hangup_req(hangup_req), .dedicated_line(dedicated_line),
      .tmo_cycles(tmo_cycles),
      .ring(ring), .modem_rdy(modem_rdy), .carrier(carrier),
      .clr_to_send(clr_to_send),
      .term_rdy(term_rdy), .req_to_send(req_to_send), .tx_permit(tx_permit),
      .link_up(link_up), .err_timeout(err_timeout)
   );

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // packed as {term_rdy, req_to_send, tx_permit, link_up, err_timeout}
   task automatic expect_outs(string req, logic [4:0] exp);
      logic [4:0] act;
      act = {term_rdy, req_to_send, tx_permit, link_up, err_timeout};
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: outs(dtr,rts,perm,link,err) actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      tick(1);
      sig = 1'b0;
   endtask

   task automatic test_reset();
      expect_outs("R1", 5'b00000);
   endtask

   task automatic test_originate();
      pulse(call_req);
      tick(4);  expect_outs("R2 dtr up", 5'b10000);
      modem_rdy = 1;
      tick(4);  expect_outs("R2 ready alone", 5'b10000);
      modem_rdy = 0; carrier = 1;
      tick(4);  expect_outs("R2 carrier alone", 5'b10000);
      modem_rdy = 1;
      tick(4);  expect_outs("R2 linked", 5'b10010);
   endtask

   task automatic test_data_phase();
      send_req = 1;
      tick(4);  expect_outs("R5 rts no cts", 5'b11010);
      clr_to_send = 1;
      tick(4);  expect_outs("R5 permit", 5'b11110);
      clr_to_send = 0;
      tick(4);  expect_outs("R5 cts drop", 5'b11010);
      clr_to_send = 1;
      tick(4);  expect_outs("R5 permit again", 5'b11110);
      send_req = 0;
      tick(4);  expect_outs("R6 send off", 5'b10010);
   endtask

   task automatic test_hangup_order();
      send_req = 1;
      tick(4);  expect_outs("R7 pre", 5'b11110);
      pulse(hangup_req);
      send_req = 0;
      tick(3);  expect_outs("R7 rts first", 5'b10000);
      clr_to_send = 0;
      tick(4);  expect_outs("R7 after cts", 5'b10000);
      modem_rdy = 0;
      tick(4);  expect_outs("R7 carrier held", 5'b10000);
      carrier = 0;
      tick(4);  expect_outs("R7 dtr released", 5'b00000);
   endtask

   task automatic test_answer_and_loss();
      pulse(answer_req);
      tick(10); expect_outs("R3 armed", 5'b00000);
      ring = 1;
      tick(4);  expect_outs("R3 accept", 5'b10000);
      ring = 0; modem_rdy = 1; carrier = 1;
      tick(4);  expect_outs("R3 linked", 5'b10010);
      carrier = 0;
      tick(4);  expect_outs("R8 carrier loss", 5'b10000);
      modem_rdy = 0;
      tick(4);  expect_outs("R8 teardown end", 5'b00000);
   endtask

   task automatic test_dedicated();
      dedicated_line = 1;
      pulse(call_req);
      tick(4);  expect_outs("R4 no dtr", 5'b00000);
      modem_rdy = 1;
      tick(4);  expect_outs("R4 linked", 5'b00010);
      tick(8);  expect_outs("R8 carrier ignored", 5'b00010);
      pulse(hangup_req);
      tick(4);  expect_outs("R4 end", 5'b00000);
      dedicated_line = 0; modem_rdy = 0;
      tick(4);
   endtask

   task automatic test_timeout();
      tmo_cycles = 16'd20;
      pulse(call_req);
      tick(10); expect_outs("R9 still waiting", 5'b10000);
      tick(20); expect_outs("R9 aborted", 5'b00001);
      tick(5);  expect_outs("R10 sticky", 5'b00001);
      tmo_cycles = 16'd0;
      pulse(call_req);
      tick(1);  expect_outs("R10 cleared", 5'b10000);
      tick(60); expect_outs("R9 limit off", 5'b10000);
      pulse(hangup_req);
      tick(2);  expect_outs("R9 hangup idle", 5'b00000);
   endtask

   task automatic test_ring_wait();
      tmo_cycles = 16'd20;
      pulse(answer_req);
      tick(60); expect_outs("R11 untimed", 5'b00000);
      pulse(hangup_req);
      ring = 1;
      tick(6);  expect_outs("R11 ring ignored", 5'b00000);
      ring = 0;
      tick(4);
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      test_reset();
      test_originate();
      test_data_phase();
      test_hangup_order();
      test_answer_and_loss();
      test_dedicated();
      test_timeout();
      test_ring_wait();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule